// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock recovered from incoming serial data runs close enough to a local reference clock. The recovered clock is presented as a pulse on `rec_pulse`, one pulse per recovered cycle, sampled on reference-clock edges. Over a fixed window of reference cycles the block counts these pulses and compares the total with two bands centred on the expected count. The narrower band is used to gain lock and the wider band is used to keep it.

`lockdet` reports lock to data. `force_ref` tells the recovery loop to track the reference instead of the data. Lock is declared only after a set number of consecutive windows fall inside the narrow band. A single window outside the wide band drops lock. A signal-detect input, read through a polarity select, also drops lock and restarts measurement while the signal is absent. After a lost reference, a reset restarts everything.

Top module: `freq_lock_det`

## Requirements
- R1: While `rst_n` is low, and after it, `lockdet` is 0 and `force_ref` is 1 until lock is acquired.
- R2: A window is `WIN_CYC` consecutive reference edges. The first window starts at the first edge where reset is released and the signal is present, and the next one starts right after it. `rec_pulse` is counted at every edge of the window, including the last one.
- R3: A window is in the lock band when its count C satisfies EXP_CNT-dL <= C <= EXP_CNT+dL, with dL = floor(EXP_CNT*LOCK_PPM/1e6). Both ends are included.
- R4: From the unlocked state, `lockdet` rises just after the last edge of the `ACQ_WIN`-th consecutive window in the lock band (the default is 2). One such window alone does not raise it.
- R5: While unlocked, any window outside the lock band resets the run of good windows. This includes counts that lie inside the unlock band.
- R6: While locked, `lockdet` stays 1 for any count with EXP_CNT-dU <= C <= EXP_CNT+dU, where dU = floor(EXP_CNT*UNLOCK_PPM/1e6). Both ends are included.
- R7: While locked, a single window whose count is below EXP_CNT-dU or above EXP_CNT+dU clears `lockdet` just after that window's last edge.
- R8: `force_ref` is always the inverse of `lockdet`.
- R9: The signal is present when `sd_in` is 1 with `sd_pol`=0, or when `sd_in` is 0 with `sd_pol`=1. At any edge where the signal is absent, `lockdet` drops, the window and the good-window run restart, and measurement resumes at the first edge where the signal is present again.
- R10: Asserting reset while locked clears lock. Afterwards, `ACQ_WIN` fresh in-band windows are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_pulse | input | 1 | One pulse per recovered-clock cycle, sampled on `clk` |
| sd_in | input | 1 | Signal-detect input |
| sd_pol | input | 1 | Signal-detect polarity: 0 means active high, 1 means active low |
| lockdet | output | 1 | 1 while locked to data |
| force_ref | output | 1 | 1 while the loop must track the reference |

## Verification
The bench places counts exactly on each band edge and one step past it. A design with an off-by-one comparison would lock or unlock a window too early or too late. It breaks a run of good windows with a count that lies between the two bands. A design that shared one band for both directions, or that failed to clear the run, would lock one window early. Pulses packed into the final cycles of a window catch a counter that drops the last sample. Signal loss under both polarities, and reset during lock, show whether acquisition really starts over.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic {
    FLK_HUNT   = 1'b0,
    FLK_LOCKED = 1'b1
  } flk_state_e;

  // Offset in counts for a given ppm limit, rounded down.
  function automatic int unsigned ppm_delta(input int unsigned exp_cnt,
                                            input int unsigned ppm);
    longint unsigned prod;
    prod = longint'(exp_cnt) * longint'(ppm);
    return int'(prod / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/flk_window.sv
module flk_window #(
  parameter int unsigned WIN_CYC = 4096,
  parameter int unsigned CW      = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_ok,
  input  logic          pulse,
  output logic          win_end,
  output logic [CW-1:0] meas
);
  localparam int unsigned WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

  logic [WW-1:0] win_q;
  logic [CW-1:0] cnt_q;

  assign win_end = sig_ok && (win_q == LAST);
  assign meas    = cnt_q + CW'(pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (!sig_ok || win_end) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_q + WW'(1);
      cnt_q <= meas;
    end
  end
endmodule

// File: rtl/flk_classify.sv
module flk_classify
  import flk_pkg::*;
#(
  parameter int unsigned EXP_CNT    = 2048,
  parameter int unsigned LOCK_PPM   = 2000,
  parameter int unsigned UNLOCK_PPM = 5000,
  parameter int unsigned CW         = 13
) (
  input  logic [CW-1:0] meas,
  output logic          in_lock,
  output logic          out_unlock
);
  localparam int unsigned DL = ppm_delta(EXP_CNT, LOCK_PPM);
  localparam int unsigned DU = ppm_delta(EXP_CNT, UNLOCK_PPM);
  localparam logic [CW-1:0] LK_LO = CW'(EXP_CNT - DL);
  localparam logic [CW-1:0] LK_HI = CW'(EXP_CNT + DL);
  localparam logic [CW-1:0] UL_LO = CW'(EXP_CNT - DU);
  localparam logic [CW-1:0] UL_HI = CW'(EXP_CNT + DU);

  assign in_lock    = (meas >= LK_LO) && (meas <= LK_HI);
  assign out_unlock = (meas < UL_LO) || (meas > UL_HI);
endmodule

// File: rtl/flk_state.sv
module flk_state
  import flk_pkg::*;
#(
  parameter int unsigned ACQ_WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_ok,
  input  logic win_end,
  input  logic in_lock,
  input  logic out_unlock,
  output logic locked
);
  localparam int unsigned SW = $clog2(ACQ_WIN + 1);
  localparam logic [SW-1:0] NEED = SW'(ACQ_WIN - 1);

  flk_state_e    st_q;
  logic [SW-1:0] run_q;

  assign locked = (st_q == FLK_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FLK_HUNT;
      run_q <= '0;
    end else if (!sig_ok) begin
      st_q  <= FLK_HUNT;
      run_q <= '0;
    end else if (win_end) begin
      if (st_q == FLK_HUNT) begin
        if (!in_lock) begin
          run_q <= '0;
        end else if (run_q >= NEED) begin
          st_q  <= FLK_LOCKED;
          run_q <= '0;
        end else begin
          run_q <= run_q + SW'(1);
        end
      end else if (out_unlock) begin
        st_q  <= FLK_HUNT;
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int unsigned WIN_CYC    = 4096,
  parameter int unsigned EXP_CNT    = 2048,
  parameter int unsigned LOCK_PPM   = 2000,
  parameter int unsigned UNLOCK_PPM = 5000,
  parameter int unsigned ACQ_WIN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_pulse,
  input  logic sd_in,
  input  logic sd_pol,
  output logic lockdet,
  output logic force_ref
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);

  logic          sig_ok;
  logic          win_end;
  logic          in_lock;
  logic          out_unlock;
  logic [CW-1:0] meas;
  logic          locked;

  assign sig_ok = sd_in ^ sd_pol;

  flk_window #(.WIN_CYC(WIN_CYC), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .pulse(rec_pulse),
    .win_end(win_end), .meas(meas)
  );

  flk_classify #(.EXP_CNT(EXP_CNT), .LOCK_PPM(LOCK_PPM),
                 .UNLOCK_PPM(UNLOCK_PPM), .CW(CW)) u_cls (
    .meas(meas), .in_lock(in_lock), .out_unlock(out_unlock)
  );

  flk_state #(.ACQ_WIN(ACQ_WIN)) u_st (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .win_end(win_end),
    .in_lock(in_lock), .out_unlock(out_unlock), .locked(locked)
  );

  assign lockdet   = locked;
  assign force_ref = ~locked;
endmodule

// File: rtl/flk_chk.sv
module flk_chk (
  input logic clk,
  input logic rst_n,
  input logic lockdet,
  input logic force_ref,
  input logic win_end,
  input logic in_lock,
  input logic out_unlock,
  input logic sig_ok
);
  // R3 R6
  band_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |-> !out_unlock);

  // R4
  rise_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockdet) |-> $past(win_end && in_lock && sig_ok));

  // R7 R9
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockdet) |-> $past((win_end && out_unlock) || !sig_ok));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockdet && sig_ok && !(win_end && out_unlock)) |=> lockdet);

  // R9
  los_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |=> (force_ref && !lockdet));

  // R8
  always_comb begin
    if (rst_n) begin
      force_inv_chk: assert (force_ref == !lockdet);
    end
  end
endmodule

bind freq_lock_det flk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lockdet(lockdet), .force_ref(force_ref),
  .win_end(win_end), .in_lock(in_lock), .out_unlock(out_unlock),
  .sig_ok(sig_ok)
);

// File: tb/freq_lock_det_bench.sv
module freq_lock_det_bench;
  localparam int WIN = 256;
  localparam int EXP = 128;
  localparam int LPPM = 50000;
  localparam int UPPM = 125000;
  localparam int DL = int'((longint'(EXP) * LPPM) / 1000000);
  localparam int DU = int'((longint'(EXP) * UPPM) / 1000000);
  localparam int LK_LO = EXP - DL;
  localparam int LK_HI = EXP + DL;
  localparam int UL_LO = EXP - DU;
  localparam int UL_HI = EXP + DU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_pulse = 1'b0;
  logic sd_in = 1'b1;
  logic sd_pol = 1'b0;
  logic lockdet, force_ref;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  freq_lock_det #(.WIN_CYC(WIN), .EXP_CNT(EXP), .LOCK_PPM(LPPM),
                  .UNLOCK_PPM(UPPM), .ACQ_WIN(2)) u_freq_lock_det (
    .clk(clk), .rst_n(rst_n), .rec_pulse(rec_pulse), .sd_in(sd_in),
    .sd_pol(sd_pol), .lockdet(lockdet), .force_ref(force_ref)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic exp_lock);
    chk(req, lockdet, exp_lock);
    chk({req, " force_ref"}, force_ref, ~exp_lock);
  endtask

  // Starts and ends at a negedge; pulses at the head or the tail of the window.
  task automatic run_window(input int n, input bit tail);
    for (int i = 0; i < WIN; i++) begin
      rec_pulse = tail ? (i >= WIN - n) : (i < n);
      @(posedge clk);
      @(negedge clk);
    end
    rec_pulse = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_out("R1 in reset", 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire;
    run_window(EXP, 1'b0);
    chk_out("R4 one window not enough", 1'b0);
    chk_out("R1 unlocked after reset", 1'b0);
    run_window(EXP, 1'b1);
    chk_out("R4 R2 lock after second window, tail pulses", 1'b1);
  endtask

  task automatic t_hold;
    run_window(UL_HI, 1'b0);
    chk_out("R6 upper unlock edge keeps lock", 1'b1);
    run_window(UL_LO, 1'b1);
    chk_out("R6 lower unlock edge keeps lock", 1'b1);
  endtask

  task automatic t_drop_high;
    run_window(UL_HI + 1, 1'b0);
    chk_out("R7 R8 above unlock band drops", 1'b0);
  endtask

  task automatic t_lock_band;
    run_window(LK_LO - 1, 1'b0);
    chk_out("R3 below lock band", 1'b0);
    run_window(LK_LO, 1'b0);
    chk_out("R3 lower lock edge first", 1'b0);
    run_window(LK_HI, 1'b0);
    chk_out("R3 upper lock edge locks", 1'b1);
    run_window(UL_LO - 1, 1'b0);
    chk_out("R7 below unlock band drops", 1'b0);
  endtask

  task automatic t_streak;
    run_window(EXP, 1'b0);
    run_window(LK_HI + 1, 1'b0);
    chk_out("R5 between bands no lock", 1'b0);
    run_window(EXP, 1'b0);
    chk_out("R5 run restarted", 1'b0);
    run_window(EXP, 1'b0);
    chk_out("R5 relock after two good", 1'b1);
  endtask

  task automatic t_sd;
    sd_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_out("R9 loss active-high drops", 1'b0);
    sd_pol = 1'b1;
    run_window(EXP, 1'b0);
    chk_out("R9 active-low present, one window", 1'b0);
    run_window(EXP, 1'b0);
    chk_out("R9 active-low relock", 1'b1);
    sd_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_out("R9 loss active-low drops", 1'b0);
    sd_in = 1'b0;
    run_window(EXP, 1'b0);
    run_window(EXP, 1'b0);
    chk_out("R9 relock after loss", 1'b1);
  endtask

  task automatic t_reset_mid;
    for (int i = 0; i < 100; i++) begin
      rec_pulse = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    rec_pulse = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_out("R10 reset clears lock", 1'b0);
    rst_n = 1'b1;
    run_window(EXP, 1'b0);
    chk_out("R10 one window after reset", 1'b0);
    run_window(EXP, 1'b0);
    chk_out("R10 relock after reset", 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_acquire();
    t_hold();
    t_drop_high();
    t_lock_band();
    t_streak();
    t_sd();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule